// File: doc/BRIEF.md
# Lower-Half Element Interleave Unit

This execution unit serves a 128-bit packed-data register file. It takes the lower 64 bits of two source registers, already read out by the pipeline, and interleaves their elements into a full 128-bit destination value. The element size is a byte, a halfword or a word. The unit also decodes the instruction word that selects the operation. Its output is a destination write port with separate low and high 64-bit lanes, a write strobe and a destination register index.

Elements are copied without change. The element with index i from the rt operand is placed in even result slot 2i, and the element with index i from the rs operand is placed in odd slot 2i+1. The low lane takes the lowest slots and the high lane takes the slots that follow. An instruction that names register 0 as its destination writes nothing. An instruction word that is not one of the three variants also writes nothing.

The result is registered, so the write port reflects the instruction presented one clock edge earlier.

Top module: `lower_interleave_unit`

## Requirements
- R1: An instruction is accepted only when bits [31:26] equal 011100, bits [5:0] equal 001000, and bits [10:6] equal 10010 (word elements), 10110 (halfword elements) or 11010 (byte elements).
- R2: For an accepted instruction, `wr_idx` carries the destination field, instruction bits [15:11].
- R3: Slots are numbered from bit 0 of the 128-bit value {`wr_hi`,`wr_lo`}. Element i of `rt_lo` goes to slot 2i and element i of `rs_lo` goes to slot 2i+1.
- R4: In byte mode, source bytes 0 to 3 of both operands fill `wr_lo` and bytes 4 to 7 fill `wr_hi`. For example, `wr_lo[7:0]` is `rt_lo[7:0]` and `wr_lo[15:8]` is `rs_lo[7:0]`.
- R5: In halfword mode, halfwords 0 and 1 of both operands fill `wr_lo` and halfwords 2 and 3 fill `wr_hi`.
- R6: In word mode, `wr_lo` is {`rs_lo[31:0]`,`rt_lo[31:0]`} and `wr_hi` is {`rs_lo[63:32]`,`rt_lo[63:32]`}.
- R7: An accepted instruction whose destination field is 0 leaves `wr_en` low, with both lanes and `wr_idx` at zero.
- R8: Any instruction word that is not accepted under R1 leaves `wr_en` low, with both lanes and `wr_idx` at zero.
- R9: All outputs are registered. They change one rising clock edge after the inputs are presented, and they are all zero while `rst_n` is low.
- R10: Elements are copied bit for bit, with no sign or zero extension, so an element whose top bit is set appears unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_word | input | 32 | Instruction word to decode |
| rs_lo | input | 64 | Lower 64 bits of the rs source register |
| rt_lo | input | 64 | Lower 64 bits of the rt source register |
| wr_lo | output | 64 | Low 64-bit lane of the destination value |
| wr_hi | output | 64 | High 64-bit lane of the destination value |
| wr_en | output | 1 | Destination write strobe |
| wr_idx | output | 5 | Destination register index |

## Verification
Each of the three element widths is driven with random operands and also with one operand pair in which every element holds its own slot number. The random operands show that every result bit is taken from some source bit. The slot-numbered pair shows at once which element landed where, so a swapped operand or a shifted slot shows up immediately. Operands with the top bit of every element set separate a plain copy from an extending copy. Near-miss instruction words, each differing from a valid encoding in one field, together with a zero destination field, show that the write strobe depends on each field of the encoding. A wrong encoding that follows a valid one shows that a stale result does not linger on the port.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int INSN_W    = 32;
  localparam int IDX_W     = 5;
  localparam int LANE_W    = 64;
  localparam int FULL_W    = 2 * LANE_W;
  localparam int N_VARIANT = 3;

  // select-vector bit positions
  localparam int SEL_B8  = 0;
  localparam int SEL_B16 = 1;
  localparam int SEL_B32 = 2;

  localparam logic [5:0] MAJOR_CODE = 6'b011100;
  localparam logic [5:0] FUNC_CODE  = 6'b001000;
  localparam logic [4:0] SUB_B32    = 5'b10010;
  localparam logic [4:0] SUB_B16    = 5'b10110;
  localparam logic [4:0] SUB_B8     = 5'b11010;

  typedef struct packed {
    logic [5:0]       major;
    logic [IDX_W-1:0] src_s;
    logic [IDX_W-1:0] src_t;
    logic [IDX_W-1:0] dst;
    logic [4:0]       sub;
    logic [5:0]       func;
  } insn_t;

  function automatic int elem_width(input int variant);
    return 8 << variant;
  endfunction
endpackage

// File: rtl/ilv_decode.sv
module ilv_decode
  import ilv_pkg::*;
(
  input  logic [INSN_W-1:0]    insn_word,
  output logic [N_VARIANT-1:0] sel,
  output logic                 hit,
  output logic [IDX_W-1:0]     dst_idx
);
  insn_t f;
  logic  frame_ok;
  logic  unused_src_fields;

  assign f        = insn_t'(insn_word);
  assign frame_ok = (f.major == MAJOR_CODE) && (f.func == FUNC_CODE);

  always_comb begin
    sel          = '0;
    sel[SEL_B8]  = frame_ok && (f.sub == SUB_B8);
    sel[SEL_B16] = frame_ok && (f.sub == SUB_B16);
    sel[SEL_B32] = frame_ok && (f.sub == SUB_B32);
  end

  assign hit               = |sel;
  assign dst_idx           = f.dst;
  assign unused_src_fields = ^{f.src_s, f.src_t};
endmodule

// File: rtl/ilv_lanes.sv
module ilv_lanes
  import ilv_pkg::*;
#(
  parameter int ELEM_W = 8
) (
  input  logic [LANE_W-1:0] odd_src,
  input  logic [LANE_W-1:0] even_src,
  output logic [LANE_W-1:0] lane_lo,
  output logic [LANE_W-1:0] lane_hi
);
  localparam int N_ELEM = LANE_W / ELEM_W;
  logic [FULL_W-1:0] full;

  for (genvar i = 0; i < N_ELEM; i++) begin : g_elem
    assign full[(2*i)*ELEM_W   +: ELEM_W] = even_src[i*ELEM_W +: ELEM_W];
    assign full[(2*i+1)*ELEM_W +: ELEM_W] = odd_src[i*ELEM_W +: ELEM_W];
  end

  assign lane_lo = full[LANE_W-1:0];
  assign lane_hi = full[FULL_W-1:LANE_W];
endmodule

// File: rtl/lower_interleave_unit.sv
module lower_interleave_unit
  import ilv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       insn_word,
  input  logic [63:0]       rs_lo,
  input  logic [63:0]       rt_lo,
  output logic [63:0]       wr_lo,
  output logic [63:0]       wr_hi,
  output logic              wr_en,
  output logic [4:0]        wr_idx
);
  logic [N_VARIANT-1:0]             dec_sel;
  logic                             dec_hit;
  logic [IDX_W-1:0]                 dec_dst;
  logic [N_VARIANT-1:0][LANE_W-1:0] cand_lo;
  logic [N_VARIANT-1:0][LANE_W-1:0] cand_hi;
  logic [LANE_W-1:0]                mux_lo;
  logic [LANE_W-1:0]                mux_hi;
  logic                             do_write;

  ilv_decode u_dec (
    .insn_word (insn_word),
    .sel       (dec_sel),
    .hit       (dec_hit),
    .dst_idx   (dec_dst)
  );

  for (genvar v = 0; v < N_VARIANT; v++) begin : g_var
    ilv_lanes #(.ELEM_W(elem_width(v))) u_lanes (
      .odd_src  (rs_lo),
      .even_src (rt_lo),
      .lane_lo  (cand_lo[v]),
      .lane_hi  (cand_hi[v])
    );
  end

  assign do_write = dec_hit && (dec_dst != '0);

  always_comb begin
    mux_lo = '0;
    mux_hi = '0;
    for (int v = 0; v < N_VARIANT; v++) begin
      mux_lo |= cand_lo[v] & {LANE_W{dec_sel[v] & do_write}};
      mux_hi |= cand_hi[v] & {LANE_W{dec_sel[v] & do_write}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_lo  <= '0;
      wr_hi  <= '0;
      wr_en  <= 1'b0;
      wr_idx <= '0;
    end else begin
      wr_lo  <= mux_lo;
      wr_hi  <= mux_hi;
      wr_en  <= do_write;
      wr_idx <= do_write ? dec_dst : '0;
    end
  end
endmodule

// File: rtl/ilv_checker.sv
module ilv_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] insn_word,
  input logic [63:0] rs_lo,
  input logic [63:0] rt_lo,
  input logic [63:0] wr_lo,
  input logic [63:0] wr_hi,
  input logic        wr_en,
  input logic [4:0]  wr_idx
);
  a_r1_accept_frame: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(insn_word[31:26]) == 6'b011100 && $past(insn_word[5:0]) == 6'b001000));

  a_r2_dest_index: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx == $past(insn_word[15:11]));

  a_r7_rd_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(insn_word[15:11]) == 5'd0) |-> !wr_en);

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (wr_lo == 64'd0 && wr_hi == 64'd0 && wr_idx == 5'd0));

  a_r6_word_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(insn_word[10:6]) == 5'b10010) |->
      (wr_lo == {$past(rs_lo[31:0]), $past(rt_lo[31:0])} &&
       wr_hi == {$past(rs_lo[63:32]), $past(rt_lo[63:32])}));

  a_r4_byte_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(insn_word[10:6]) == 5'b11010) |->
      (wr_lo[15:0] == {$past(rs_lo[7:0]), $past(rt_lo[7:0])} &&
       wr_hi[63:48] == {$past(rs_lo[63:56]), $past(rt_lo[63:56])}));

  a_r5_half_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(insn_word[10:6]) == 5'b10110) |->
      (wr_lo[31:0] == {$past(rs_lo[15:0]), $past(rt_lo[15:0])} &&
       wr_hi[31:0] == {$past(rs_lo[47:32]), $past(rt_lo[47:32])}));
endmodule

bind lower_interleave_unit ilv_checker u_ilv_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .insn_word (insn_word),
  .rs_lo     (rs_lo),
  .rt_lo     (rt_lo),
  .wr_lo     (wr_lo),
  .wr_hi     (wr_hi),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx)
);

// File: tb/lower_interleave_unit_bench.sv
`timescale 1ns/1ps
module lower_interleave_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insn_word = '0;
  logic [63:0] rs_lo = '0;
  logic [63:0] rt_lo = '0;
  logic [63:0] wr_lo, wr_hi;
  logic        wr_en;
  logic [4:0]  wr_idx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lower_interleave_unit u_lower_interleave_unit (
    .clk(clk), .rst_n(rst_n), .insn_word(insn_word),
    .rs_lo(rs_lo), .rt_lo(rt_lo),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_en(wr_en), .wr_idx(wr_idx)
  );

  localparam logic [4:0] K_W = 5'b10010;
  localparam logic [4:0] K_H = 5'b10110;
  localparam logic [4:0] K_B = 5'b11010;

  function automatic logic [31:0] enc(input logic [4:0] sub, input logic [4:0] rd);
    return {6'b011100, 5'd3, 5'd7, rd, sub, 6'b001000};
  endfunction

  // builds the 128-bit result slot by slot: even slots from rt, odd from rs
  function automatic logic [127:0] model(input logic [63:0] a, input logic [63:0] b, input int w);
    logic [127:0] r = '0;
    for (int s = 0; s < 128 / w; s++) begin
      for (int k = 0; k < w; k++) begin
        r[s*w + k] = (s % 2 == 1) ? a[(s/2)*w + k] : b[(s/2)*w + k];
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] iw, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    insn_word = iw; rs_lo = a; rt_lo = b;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_write(input string req, input logic [4:0] sub, input int w,
                              input logic [4:0] rd, input logic [63:0] a, input logic [63:0] b);
    logic [127:0] e;
    e = model(a, b, w);
    issue(enc(sub, rd), a, b);
    check({req, " wr_en"}, {63'd0, wr_en}, 64'd1);
    check("R2 wr_idx", {59'd0, wr_idx}, {59'd0, rd});
    check({req, " R3 wr_lo"}, wr_lo, e[63:0]);
    check({req, " R3 wr_hi"}, wr_hi, e[127:64]);
  endtask

  task automatic expect_idle(input string req, input logic [31:0] iw);
    issue(iw, 64'hDEAD_BEEF_0123_4567, 64'h89AB_CDEF_FEED_F00D);
    check({req, " wr_en"}, {63'd0, wr_en}, 64'd0);
    check({req, " wr_lo"}, wr_lo, 64'd0);
    check({req, " wr_hi"}, wr_hi, 64'd0);
    check({req, " wr_idx"}, {59'd0, wr_idx}, 64'd0);
  endtask

  task automatic t_reset();
    #1;
    check("R9 reset wr_en", {63'd0, wr_en}, 64'd0);
    check("R9 reset wr_lo", wr_lo, 64'd0);
    check("R9 reset wr_hi", wr_hi, 64'd0);
    check("R9 reset wr_idx", {59'd0, wr_idx}, 64'd0);
  endtask

  task automatic t_latency();
    // R9: output reflects the new instruction only after the edge
    @(negedge clk);
    insn_word = enc(K_W, 5'd9); rs_lo = 64'h1111_2222_3333_4444; rt_lo = 64'h5555_6666_7777_8888;
    #0.5;
    check("R9 before edge", {63'd0, wr_en}, 64'd0);
    @(posedge clk); #1;
    check("R9 after edge", wr_lo, 64'h3333_4444_7777_8888);
  endtask

  task automatic t_word();
    expect_write("R6", K_W, 32, 5'd1, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444);
    check("R6 exact lo", wr_lo, 64'hCCCC_DDDD_3333_4444);
    check("R6 exact hi", wr_hi, 64'hAAAA_BBBB_1111_2222);
    for (int i = 0; i < 6; i++)
      expect_write("R6", K_W, 32, 5'(i + 2), {$urandom, $urandom}, {$urandom, $urandom});
  endtask

  task automatic t_half();
    expect_write("R5", K_H, 16, 5'd5, 64'h0007_0005_0003_0001, 64'h0006_0004_0002_0000);
    check("R5 exact lo", wr_lo, 64'h0003_0002_0001_0000);
    check("R5 exact hi", wr_hi, 64'h0007_0006_0005_0004);
    for (int i = 0; i < 6; i++)
      expect_write("R5", K_H, 16, 5'(i + 10), {$urandom, $urandom}, {$urandom, $urandom});
  endtask

  task automatic t_byte();
    expect_write("R4", K_B, 8, 5'd31, 64'h0F0D_0B09_0705_0301, 64'h0E0C_0A08_0604_0200);
    check("R4 exact lo", wr_lo, 64'h0706_0504_0302_0100);
    check("R4 exact hi", wr_hi, 64'h0F0E_0D0C_0B0A_0908);
    for (int i = 0; i < 6; i++)
      expect_write("R4", K_B, 8, 5'(i + 20), {$urandom, $urandom}, {$urandom, $urandom});
  endtask

  task automatic t_no_extend();
    expect_write("R10 byte", K_B, 8, 5'd4, 64'h8182_8384_8586_8788, 64'hF1F2_F3F4_F5F6_F7F8);
    check("R10 byte hi", wr_hi, 64'h81F1_82F2_83F3_84F4);
    expect_write("R10 half", K_H, 16, 5'd4, 64'h8000_9000_A000_B000, 64'hFFFF_8001_C000_8888);
    check("R10 half lo", wr_lo, 64'hA000_C000_B000_8888);
  endtask

  task automatic t_rd_zero();
    expect_idle("R7 word rd0", enc(K_W, 5'd0));
    expect_idle("R7 half rd0", enc(K_H, 5'd0));
    expect_idle("R7 byte rd0", enc(K_B, 5'd0));
  endtask

  task automatic t_bad();
    logic [31:0] g;
    g = enc(K_B, 5'd6);
    expect_idle("R8 major", {6'b011101, g[25:0]});
    expect_idle("R8 func", {g[31:6], 6'b001001});
    expect_idle("R8 sub 00010", {g[31:11], 5'b00010, g[5:0]});
    expect_idle("R1 sub 10011", {g[31:11], 5'b10011, g[5:0]});
    expect_idle("R1 sub 11110", {g[31:11], 5'b11110, g[5:0]});
    // valid then invalid: the stale result must not linger
    expect_write("R8 prior", K_H, 16, 5'd12, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
    expect_idle("R8 after valid", 32'h0000_0000);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_latency();
    t_word();
    t_half();
    t_byte();
    t_no_extend();
    t_rd_zero();
    t_bad();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule